// File: doc/BRIEF.md
# Parallel-Port Nibble Reverse Receiver

This block is the host-side engine for the reverse (peripheral-to-host) channel of a parallel port. It works in four-bit units. A mode controller enables it. While enabled, it drives an active-low host-busy line low to ask the peripheral for a nibble. The peripheral puts four data bits on its status lines and pulls its active-low clock line low to mark them valid. The engine latches the nibble, raises host-busy to acknowledge, and waits for the peripheral clock to return high before it asks for more.

Two nibbles make one byte. The byte is offered to the host logic on a valid/ready interface and held there until it is taken. Every status input passes through a synchroniser before use. A programmable cycle limit guards both handshake waits, so a silent or stuck peripheral cannot hang the engine. The forward data strobe is held negated throughout.

Top module: `nibble_rx`

## Requirements
- R1: A byte is built from two nibbles in order: the first nibble received becomes bits 3:0 and the second becomes bits 7:4.
- R2: A status line at logic 1 gives a data bit of 1. Within each nibble, `stDataAvail` carries the lowest bit, `stXflag` the next, `stAckReq` the third and `stBusy` the highest. Across the byte this gives bits 0/4, 1/5, 2/6 and 3/7 respectively.
- R3: The engine requests a nibble by holding `hostBusyN` low. It latches the nibble only on a synchronised falling edge of `ptrClkN`. It then drives `hostBusyN` high; with the default two-stage synchroniser this happens three cycles after `ptrClkN` falls.
- R4: `hostBusyN` is driven low only when the synchronised `ptrClkN` was high in the previous cycle. While the peripheral holds `ptrClkN` low, no new request starts.
- R5: `strobeN` is always high.
- R6: While `enable` is low, `hostBusyN` is high and `byteValid` is low. Dropping `enable` mid-byte abandons the partial byte, and the next byte starts afresh from its low nibble.
- R7: Once both nibbles are in, `byteValid` stays high and `byteData` stays unchanged until `byteReady` is seen. No request is made during that time, and `byteValid` falls the cycle after the transfer.
- R8: If the engine stays in either handshake wait (waiting for `ptrClkN` to fall, or waiting for it to rise) for `timeoutLimit`+1 cycles, it pulses `timeoutErr` high for exactly one cycle. In that cycle it returns to idle with `hostBusyN` high. `timeoutLimit` must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Reverse nibble mode active (from the mode controller) |
| timeoutLimit | input | TO_W | Handshake wait limit, in cycles, minus one |
| stDataAvail | input | 1 | Peripheral status line carrying bits 0 and 4 |
| stXflag | input | 1 | Peripheral status line carrying bits 1 and 5 |
| stAckReq | input | 1 | Peripheral status line carrying bits 2 and 6 |
| stBusy | input | 1 | Peripheral status line carrying bits 3 and 7 |
| ptrClkN | input | 1 | Peripheral nibble clock, active low |
| hostBusyN | output | 1 | Host busy / nibble request, active low |
| strobeN | output | 1 | Forward data strobe, held negated |
| byteData | output | 8 | Assembled byte |
| byteValid | output | 1 | Byte available |
| byteReady | input | 1 | Consumer accepts the byte |
| timeoutErr | output | 1 | One-cycle pulse on handshake timeout |

## Verification
The assertions check the following on every cycle:
- a disabled engine is idle;
- the byte and its valid flag hold still while the consumer stalls;
- no request is made while a byte is pending;
- a new request starts only from a released peripheral clock;
- a nibble is latched only on a synchronised clock fall;
- a timeout pulse is single and coincides with idle.

Only the bench scenarios can show the following:
- the scattered bit mapping and the low-then-high nibble order, exercised with walking-one and mixed bytes;
- the exact acknowledge latency;
- the exact timeout cycle count in each wait;
- the clean restart after an abandoned byte.

// File: rtl/nibble_rx_pkg.sv
package nibble_rx_pkg;
  localparam int NIB_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int NIB_CNT = BYTE_W / NIB_W;
  localparam int SLOT_W  = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RELEASE,
    ST_HOLD
  } rxState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              latch;
    logic [SLOT_W-1:0] slot;
  } dpCmd_t;

  // datapath -> control observations
  typedef struct packed {
    logic clkFall;
    logic clkHigh;
  } dpStat_t;
endpackage

// File: rtl/nibble_rx_dp.sv
module nibble_rx_dp
  import nibble_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W:0]    rawLines,   // [NIB_W] is the peripheral clock
  input  dpCmd_t            cmd,
  output dpStat_t           stat,
  output logic [BYTE_W-1:0] byteData
);
  localparam int CLK_IDX = NIB_W;

  logic [NIB_W:0] synced;
  logic           prevClk;
  logic [BYTE_W-1:0] byteReg;

  // synchronisers: clock line resets high, data lines low
  for (genvar i = 0; i <= NIB_W; i++) begin : g_sync
    localparam logic RST_V = (i == CLK_IDX);
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{RST_V}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawLines[i]};
    end
    assign synced[i] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b1;
    else       prevClk <= synced[CLK_IDX];
  end

  assign stat.clkFall = prevClk & ~synced[CLK_IDX];
  assign stat.clkHigh = synced[CLK_IDX];

  // one storage slot per nibble position
  for (genvar s = 0; s < NIB_CNT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        byteReg[s*NIB_W +: NIB_W] <= '0;
      else if (cmd.latch && cmd.slot == SLOT_W'(s))
        byteReg[s*NIB_W +: NIB_W] <= synced[NIB_W-1:0];
    end
  end

  assign byteData = byteReg;

  // R3: a latch strobe only ever coincides with a synchronised clock fall
  p_latch_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.latch |-> stat.clkFall);
endmodule

// File: rtl/nibble_rx_ctrl.sv
module nibble_rx_ctrl
  import nibble_rx_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [TO_W-1:0] timeoutLimit,
  input  logic            byteReady,
  input  dpStat_t         stat,
  output dpCmd_t          cmd,
  output logic            hostBusyN,
  output logic            byteValid,
  output logic            timeoutErr
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NIB_CNT - 1);

  rxState_t          state, stNext;
  logic [SLOT_W-1:0] slot, slotNext;
  logic [TO_W-1:0]   waitCnt;
  logic              errQ, errSet, latch, inWait, expire;

  assign inWait = (state == ST_REQ) || (state == ST_RELEASE);
  assign expire = (waitCnt == timeoutLimit);

  always_comb begin
    stNext   = state;
    slotNext = slot;
    latch    = 1'b0;
    errSet   = 1'b0;
    case (state)
      ST_IDLE: begin
        slotNext = '0;
        if (stat.clkHigh) stNext = ST_REQ;
      end
      ST_REQ: begin
        if (stat.clkFall) begin
          latch  = 1'b1;
          stNext = ST_RELEASE;
        end else if (expire) begin
          errSet = 1'b1;
          stNext = ST_IDLE;
        end
      end
      ST_RELEASE: begin
        if (stat.clkHigh) begin
          if (slot == LAST_SLOT) stNext = ST_HOLD;
          else begin
            slotNext = slot + 1'b1;
            stNext   = ST_REQ;
          end
        end else if (expire) begin
          errSet = 1'b1;
          stNext = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (byteReady) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
    if (!enable) begin
      stNext   = ST_IDLE;
      slotNext = '0;
      latch    = 1'b0;
      errSet   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slot    <= '0;
      waitCnt <= '0;
      errQ    <= 1'b0;
    end else begin
      state   <= stNext;
      slot    <= slotNext;
      waitCnt <= (stNext != state || !inWait) ? '0 : waitCnt + 1'b1;
      errQ    <= errSet;
    end
  end

  assign cmd.latch  = latch;
  assign cmd.slot   = slot;
  assign hostBusyN  = (state != ST_REQ);
  assign byteValid  = (state == ST_HOLD);
  assign timeoutErr = errQ;

  p_idle_when_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hostBusyN && !byteValid));

  p_no_req_while_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> hostBusyN);

  p_req_after_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostBusyN) |-> $past(stat.clkHigh));

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (hostBusyN && !byteValid));

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);
endmodule

// File: rtl/nibble_rx.sv
module nibble_rx
  import nibble_rx_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic              stDataAvail,
  input  logic              stXflag,
  input  logic              stAckReq,
  input  logic              stBusy,
  input  logic              ptrClkN,
  output logic              hostBusyN,
  output logic              strobeN,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  input  logic              byteReady,
  output logic              timeoutErr
);
  dpCmd_t  cmd;
  dpStat_t stat;

  nibble_rx_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .timeoutLimit(timeoutLimit),
    .byteReady(byteReady), .stat(stat), .cmd(cmd), .hostBusyN(hostBusyN),
    .byteValid(byteValid), .timeoutErr(timeoutErr)
  );

  nibble_rx_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .rawLines({ptrClkN, stBusy, stAckReq, stXflag, stDataAvail}),
    .cmd(cmd), .stat(stat), .byteData(byteData)
  );

  // R5: forward strobe is never asserted in this mode
  assign strobeN = 1'b1;

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteReady && enable) |=> (byteValid && $stable(byteData)));
endmodule

// File: tb/sim_nibble_rx.sv
module sim_nibble_rx;
  localparam int TO_W  = 16;
  localparam int LIMIT = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [TO_W-1:0] timeoutLimit = TO_W'(LIMIT);
  logic stDataAvail = 1'b0, stXflag = 1'b0, stAckReq = 1'b0, stBusy = 1'b0;
  logic ptrClkN = 1'b1;
  logic byteReady = 1'b0;
  logic hostBusyN, strobeN, byteValid, timeoutErr;
  logic [7:0] byteData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nibble_rx #(.TO_W(TO_W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .timeoutLimit(timeoutLimit),
    .stDataAvail(stDataAvail), .stXflag(stXflag), .stAckReq(stAckReq),
    .stBusy(stBusy), .ptrClkN(ptrClkN), .hostBusyN(hostBusyN),
    .strobeN(strobeN), .byteData(byteData), .byteValid(byteValid),
    .byteReady(byteReady), .timeoutErr(timeoutErr)
  );

  // {ready delay[3:0], byte[7:0]}
  localparam logic [11:0] VEC [10] = '{
    12'h3_A5, 12'h0_01, 12'h1_02, 12'h2_04, 12'h0_08,
    12'h4_10, 12'h0_20, 12'h1_40, 12'h6_80, 12'h2_FF
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic putNib(input logic [3:0] n);
    {stBusy, stAckReq, stXflag, stDataAvail} = n;
  endtask

  task automatic waitReq();
    while (hostBusyN !== 1'b0) @(negedge clk);
  endtask

  task automatic sendNib(input logic [3:0] n);
    waitReq();
    putNib(n);
    @(negedge clk);
    ptrClkN = 1'b0;
    while (hostBusyN !== 1'b1) @(negedge clk);
    @(negedge clk);
    ptrClkN = 1'b1;
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendNib(b[3:0]);
    sendNib(b[7:4]);
  endtask

  task automatic waitValid();
    while (byteValid !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all R): actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] held;
    bit ok;

    // reset state
    repeat (3) @(negedge clk);
    chk(hostBusyN === 1'b1 && byteValid === 1'b0 && timeoutErr === 1'b0,
        "R6 reset idle", {hostBusyN, byteValid, timeoutErr}, 3'b100);
    chk(strobeN === 1'b1, "R5 strobe at reset", strobeN, 1);
    rstN = 1'b1;

    // disabled: no request
    ok = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (hostBusyN !== 1'b1 || byteValid !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R6 disabled stays idle", hostBusyN, 1);

    // vector table
    enable = 1'b1;
    foreach (VEC[i]) begin
      sendByte(VEC[i][7:0]);
      waitValid();
      chk(byteData === VEC[i][7:0], "R1 R2 byte assembly", byteData, VEC[i][7:0]);
      held = byteData;
      ok = 1'b1;
      for (int d = 0; d < int'(VEC[i][11:8]); d++) begin
        @(negedge clk);
        if (byteValid !== 1'b1 || byteData !== held || hostBusyN !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R7 hold until ready", byteData, held);
      byteReady = 1'b1;
      @(negedge clk);
      byteReady = 1'b0;
      chk(byteValid === 1'b0, "R7 valid drops after transfer", byteValid, 0);
      chk(strobeN === 1'b1, "R5 strobe negated", strobeN, 1);
    end

    // R3 acknowledge latency and R4 wait for release
    waitReq();
    putNib(4'h9);
    @(negedge clk);
    ptrClkN = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (hostBusyN !== 1'b1 && n < 20);
    chk(n == 3, "R3 ack latency", n, 3);
    ok = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (hostBusyN !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R4 no request while clock low", hostBusyN, 1);
    ptrClkN = 1'b1;
    sendNib(4'h6);
    waitValid();
    chk(byteData === 8'h69, "R1 R3 slow release byte", byteData, 8'h69);
    byteReady = 1'b1;
    @(negedge clk);
    byteReady = 1'b0;

    // R6 abort mid-byte then restart
    sendNib(4'hC);
    enable = 1'b0;
    @(negedge clk);
    ok = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (hostBusyN !== 1'b1 || byteValid !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R6 abort goes idle", {hostBusyN, byteValid}, 2'b10);
    enable = 1'b1;
    sendByte(8'h96);
    waitValid();
    chk(byteData === 8'h96, "R6 restart from low nibble", byteData, 8'h96);
    byteReady = 1'b1;
    @(negedge clk);
    byteReady = 1'b0;

    // R8 timeout while waiting for clock fall
    waitReq();
    n = 0;
    while (timeoutErr !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == LIMIT + 1, "R8 request timeout cycles", n, LIMIT + 1);
    chk(hostBusyN === 1'b1, "R8 idle on timeout", hostBusyN, 1);
    @(negedge clk);
    chk(timeoutErr === 1'b0, "R8 single pulse", timeoutErr, 0);

    // R8 timeout while waiting for clock rise
    waitReq();
    putNib(4'h3);
    @(negedge clk);
    ptrClkN = 1'b0;
    while (hostBusyN !== 1'b1) @(negedge clk);
    n = 0;
    while (timeoutErr !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == LIMIT + 1, "R8 release timeout cycles", n, LIMIT + 1);
    ok = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (hostBusyN !== 1'b1 || timeoutErr !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R4 R8 stays idle with clock low", hostBusyN, 1);
    ptrClkN = 1'b1;
    sendByte(8'h5A);
    waitValid();
    chk(byteData === 8'h5A, "R2 R8 recovery byte", byteData, 8'h5A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule